// File: doc/BRIEF.md
# Dual-Rail Return-to-Zero Pipeline Buffer

This block is a chain of word-wide pipeline stages that pass tokens over self-timed channels. On every channel each data bit travels on a pair of rails, and one acknowledge wire is shared by the whole word. A transfer is a four-phase return-to-zero exchange. The sender presents a valid code. The receiver raises the acknowledge. The sender returns every rail to zero. The receiver then lowers the acknowledge. Each stage applies a small combinational function to the token it takes in. It holds the result on its own output rails until the next stage takes it, so no separate data register exists.

Each stage checks both its input word and its output word with completion logic. A word counts as valid only when every bit has exactly one rail high. It counts as neutral only when every rail is low. An input bit with both rails high is an illegal code. It raises an error flag and is never accepted. The model is sampled by a clock so that the handshake ordering can be checked cycle by cycle. It is used wherever a word must cross several handshake hops in strict order.

Top module: `dr_pipe`

## Requirements
- R1: Each bit is encoded on a true rail (`*_t`) and a false rail (`*_f`). t=1,f=0 means logic 1. t=0,f=1 means logic 0. Both low is neutral. Both high is illegal. The output never shows an illegal bit.
- R2: Each output token equals the input token transformed once per stage. FUNC=0 passes the word through, FUNC=1 adds one modulo 2^W, and FUNC=2 inverts every bit. With the defaults (W=8, STAGES=3, FUNC=1) the output is x+3 mod 256.
- R3: Tokens leave in the order they entered, with none lost or duplicated, whatever the delays on either channel.
- R4: On an empty pipeline, when a valid input word is first sampled at clock edge 1, `in_ack` is high after edge 2 and the output word is valid after edge STAGES.
- R5: A valid output word stays unchanged while `out_ack` is low.
- R6: The output rails return to neutral only after `out_ack` has been seen high.
- R7: `in_ack` never falls while any input rail is high. After the input goes neutral, it falls once the first stage has handed its token on.
- R8: An input word with any bit having both rails high drives `code_err` high in the same cycle. While `in_ack` is low, such a word is not accepted: `in_ack` stays low and the output does not change.
- R9: While reset is held, and right after it is released, every output rail is low and `in_ack` is low. With a neutral input, `code_err` is also low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low reset, empties the pipeline |
| in_t | input | W | Input channel true rails |
| in_f | input | W | Input channel false rails |
| in_ack | output | 1 | Input channel acknowledge |
| out_t | output | W | Output channel true rails |
| out_f | output | W | Output channel false rails |
| out_ack | input | 1 | Output channel acknowledge from the consumer |
| code_err | output | 1 | High while the input carries an illegal bit |

## Verification
Each stage adds one register edge on the forward path. A token sampled at edge 1 makes `in_ack` high after edge 2 and the output valid after edge STAGES. The bench drives on falling edges and samples at the falling edge that follows each of those rising edges. `code_err` is combinational, so it is sampled in the same half cycle as the illegal word. For the remaining handshake events the wait depends on the delays of the other party. The bench therefore polls for them on falling edges and compares the data and ordering, not the cycle counts.

// File: rtl/dr_pkg.sv
package dr_pkg;
  // Per-stage transform selectors
  localparam int FN_PASS = 0;
  localparam int FN_INC  = 1;
  localparam int FN_INV  = 2;
endpackage

// File: rtl/dr_completion.sv
module dr_completion #(
  parameter int W = 8
) (
  input  logic [W-1:0] rail_t,
  input  logic [W-1:0] rail_f,
  output logic         all_valid,
  output logic         all_neutral,
  output logic         any_illegal
);
  logic [W-1:0] bit_one;
  logic [W-1:0] bit_zero;
  logic [W-1:0] bit_bad;

  // per-bit classification of the rail pair
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign bit_one[i]  = rail_t[i] ^ rail_f[i];
    assign bit_zero[i] = ~(rail_t[i] | rail_f[i]);
    assign bit_bad[i]  = rail_t[i] & rail_f[i];
  end

  // completion trees over the word
  assign all_valid   = &bit_one;
  assign all_neutral = &bit_zero;
  assign any_illegal = |bit_bad;
endmodule

// File: rtl/dr_stage.sv
module dr_stage #(
  parameter int W    = 8,
  parameter int FUNC = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_t,
  input  logic [W-1:0] in_f,
  output logic         in_ack,
  output logic [W-1:0] out_t,
  output logic [W-1:0] out_f,
  input  logic         out_ack,
  output logic         stage_err
);
  import dr_pkg::*;

  logic in_valid, in_neutral, in_illegal;
  logic out_valid, out_neutral, out_illegal;
  logic [W-1:0] word_fx;

  // named handshake events, brought out for the checker and waveforms
  logic ev_fill, ev_ack_up, ev_drain, ev_ack_dn;

  dr_completion #(.W(W)) u_in_cd (
    .rail_t(in_t), .rail_f(in_f),
    .all_valid(in_valid), .all_neutral(in_neutral), .any_illegal(in_illegal)
  );

  dr_completion #(.W(W)) u_out_cd (
    .rail_t(out_t), .rail_f(out_f),
    .all_valid(out_valid), .all_neutral(out_neutral), .any_illegal(out_illegal)
  );

  // transform chosen at elaboration
  if (FUNC == FN_INC) begin : g_inc
    assign word_fx = in_t + {{(W-1){1'b0}}, 1'b1};
  end else if (FUNC == FN_INV) begin : g_inv
    assign word_fx = ~in_t;
  end else begin : g_pass
    assign word_fx = in_t;
  end

  assign ev_fill   = in_valid && !in_ack && !out_ack && out_neutral;
  assign ev_ack_up = !in_ack && out_valid;
  assign ev_drain  = out_ack && in_ack && !out_neutral;
  assign ev_ack_dn = in_ack && in_neutral && out_neutral;

  assign stage_err = in_illegal | out_illegal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_t <= '0;
      out_f <= '0;
    end else if (ev_fill) begin
      out_t <= word_fx;
      out_f <= ~word_fx;
    end else if (ev_drain) begin
      out_t <= '0;
      out_f <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_ack <= 1'b0;
    end else if (ev_ack_up) begin
      in_ack <= 1'b1;
    end else if (ev_ack_dn) begin
      in_ack <= 1'b0;
    end
  end
endmodule

// File: rtl/dr_pipe.sv
module dr_pipe #(
  parameter int W      = 8,
  parameter int STAGES = 3,
  parameter int FUNC   = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_t,
  input  logic [W-1:0] in_f,
  output logic         in_ack,
  output logic [W-1:0] out_t,
  output logic [W-1:0] out_f,
  input  logic         out_ack,
  output logic         code_err
);
  localparam int NCH = STAGES + 1;

  logic [W-1:0]      ch_t   [NCH];
  logic [W-1:0]      ch_f   [NCH];
  logic              ch_ack [NCH];
  logic [STAGES-1:0] err_vec;

  assign ch_t[0]        = in_t;
  assign ch_f[0]        = in_f;
  assign in_ack         = ch_ack[0];
  assign ch_ack[STAGES] = out_ack;
  assign out_t          = ch_t[STAGES];
  assign out_f          = ch_f[STAGES];
  assign code_err       = |err_vec;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    dr_stage #(.W(W), .FUNC(FUNC)) u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .in_t     (ch_t[s]),
      .in_f     (ch_f[s]),
      .in_ack   (ch_ack[s]),
      .out_t    (ch_t[s+1]),
      .out_f    (ch_f[s+1]),
      .out_ack  (ch_ack[s+1]),
      .stage_err(err_vec[s])
    );
  end
endmodule

// File: rtl/dr_pipe_chk.sv
module dr_pipe_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] in_t,
  input logic [W-1:0] in_f,
  input logic         in_ack,
  input logic [W-1:0] out_t,
  input logic [W-1:0] out_f,
  input logic         out_ack,
  input logic         code_err
);
  logic out_v, out_n, in_v, in_n, in_bad;
  assign out_v  = &(out_t ^ out_f);
  assign out_n  = ~|(out_t | out_f);
  assign in_v   = &(in_t ^ in_f);
  assign in_n   = ~|(in_t | in_f);
  assign in_bad = |(in_t & in_f);

  AST_OUT_NO_ILLEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (out_t & out_f) == '0); // R1
  AST_ACK_UP_ON_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_ack) |-> $past(in_v)); // R3
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_v && !out_ack) |=> (out_t == $past(out_t) && out_f == $past(out_f))); // R5
  AST_DRAIN_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(out_v) |-> $past(out_ack)); // R6
  AST_ACK_DN_NEUTRAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ack) |-> $past(in_n)); // R7
  AST_ERR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    in_bad |-> code_err); // R8
  AST_ERR_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (in_bad && !in_ack) |=> !in_ack); // R8
  AST_RESET_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (out_n && !in_ack)); // R9
endmodule

bind dr_pipe dr_pipe_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f), .in_ack(in_ack),
  .out_t(out_t), .out_f(out_f), .out_ack(out_ack), .code_err(code_err)
);

// File: tb/dr_pipe_test.sv
module dr_pipe_test;
  localparam int W = 8;
  localparam int S = 3;
  localparam int NV = 12;
  localparam int NR = 40;

  // {input token, expected token = input + 3 mod 256}
  localparam logic [15:0] VEC [NV] = '{
    16'h0003, 16'h0104, 16'hFF02, 16'hFE01, 16'hFD00, 16'h5558,
    16'hAAAD, 16'h7F82, 16'h8083, 16'h0F12, 16'hF0F3, 16'h3C3F
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] in_t = '0;
  logic [W-1:0] in_f = '0;
  logic in_ack;
  logic [W-1:0] out_t;
  logic [W-1:0] out_f;
  logic out_ack = 1'b0;
  logic code_err;

  int total = 0;
  int bad = 0;
  logic [W-1:0] rnd [NR];

  always #5 clk = ~clk;

  dr_pipe #(.W(W), .STAGES(S), .FUNC(1)) uut (
    .clk(clk), .rst_n(rst_n), .in_t(in_t), .in_f(in_f), .in_ack(in_ack),
    .out_t(out_t), .out_f(out_f), .out_ack(out_ack), .code_err(code_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit out_valid();
    return &(out_t ^ out_f);
  endfunction

  function automatic bit out_neutral();
    return ~|(out_t | out_f);
  endfunction

  task automatic send(input logic [W-1:0] x, input int maxd);
    while (in_ack) @(negedge clk);
    in_t = x;
    in_f = ~x;
    do @(negedge clk); while (!in_ack);
    repeat ($urandom_range(maxd, 0)) @(negedge clk);
    in_t = '0;
    in_f = '0;
    while (in_ack) @(negedge clk);
  endtask

  task automatic recv(input logic [W-1:0] exp, input string tag, input int maxd);
    while (!out_valid()) @(negedge clk);
    chk(out_t == exp && out_f == ~exp, tag, int'(out_t), int'(exp));
    repeat ($urandom_range(maxd, 0)) @(negedge clk);
    out_ack = 1'b1;
    while (!out_neutral()) @(negedge clk);
    repeat ($urandom_range(maxd, 0)) @(negedge clk);
    out_ack = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R3 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk(out_neutral() && !in_ack && !code_err, "R9 reset empty",
        int'({in_ack, code_err, out_t | out_f}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_neutral() && !in_ack, "R9 after release", int'({in_ack, out_t | out_f}), 0);

    // R4 latency on empty pipe, R2 value, R5 hold, R7 ack ordering
    in_t = 8'h5A;
    in_f = ~8'h5A;
    @(negedge clk);
    chk(!in_ack, "R4 ack low after edge 1", int'(in_ack), 0);
    chk(out_neutral(), "R4 output empty after edge 1", int'(out_t | out_f), 0);
    @(negedge clk);
    chk(in_ack, "R4 ack high after edge 2", int'(in_ack), 1);
    chk(out_neutral(), "R4 output empty after edge 2", int'(out_t | out_f), 0);
    @(negedge clk);
    chk(out_valid() && out_t == 8'h5D, "R4 R2 output valid after edge 3", int'(out_t), 'h5D);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(in_ack, "R7 ack held while input valid", int'(in_ack), 1);
      chk(out_t == 8'h5D && out_f == ~8'h5D, "R5 output held", int'(out_t), 'h5D);
    end
    in_t = '0;
    in_f = '0;
    for (int k = 0; k < 10 && in_ack; k++) @(negedge clk);
    chk(!in_ack, "R7 ack falls after neutral", int'(in_ack), 0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk(out_t == 8'h5D && out_f == ~8'h5D, "R6 no drain before ack", int'(out_t), 'h5D);
    end
    out_ack = 1'b1;
    @(negedge clk);
    for (int k = 0; k < 10 && !out_neutral(); k++) @(negedge clk);
    chk(out_neutral(), "R6 drain after ack", int'(out_t | out_f), 0);
    out_ack = 1'b0;
    repeat (4) @(negedge clk);

    // R8 illegal code: bit 2 has both rails high
    in_t = 8'h06;
    in_f = 8'hFD;
    #1;
    chk(code_err, "R8 error flag", int'(code_err), 1);
    repeat (5) @(negedge clk);
    chk(!in_ack, "R8 not acknowledged", int'(in_ack), 0);
    chk(out_neutral(), "R8 output untouched", int'(out_t | out_f), 0);
    in_t = '0;
    in_f = '0;
    #1;
    chk(!code_err, "R8 error clears", int'(code_err), 0);
    @(negedge clk);

    // R2 R3 vector table with random delays
    fork
      begin
        for (int i = 0; i < NV; i++) send(VEC[i][15:8], 3);
      end
      begin
        for (int i = 0; i < NV; i++) recv(VEC[i][7:0], "R2 R3 table token", 3);
      end
    join

    // R3 random tokens, slow consumer and fast producer mixes
    for (int i = 0; i < NR; i++) rnd[i] = W'($urandom);
    fork
      begin
        for (int i = 0; i < NR; i++) send(rnd[i], (i < NR/2) ? 0 : 4);
      end
      begin
        for (int i = 0; i < NR; i++) recv(rnd[i] + 8'd3, "R3 random order", (i < NR/2) ? 5 : 0);
      end
    join

    // R9 reset with a token inside
    in_t = 8'h11;
    in_f = ~8'h11;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    in_t = '0;
    in_f = '0;
    @(negedge clk);
    chk(out_neutral() && !in_ack, "R9 mid-stream reset", int'({in_ack, out_t | out_f}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(out_neutral() && !in_ack, "R9 empty after reset", int'({in_ack, out_t | out_f}), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule